// File: doc/BRIEF.md
# Word Packer and Unpacker for a Serial Link FIFO

This block sits between a pair of 32-bit FIFOs and a serial word shifter. On the send side it takes one 32-bit FIFO entry at a time and hands out serial words in order. On the receive side it gathers serial words and hands 32-bit entries back toward the FIFO. Every port on both sides uses a valid/ready handshake.

In packed mode several short words share one entry. The first word sits in the lowest bits and each later word fills the next unit upward. In unpacked mode every entry carries a single right-justified word, and received words are masked to the programmed length. A one-cycle start pulse latches the mode, the unit-size code and the word length, and throws away any partial state. A flush pulse at the end of a transfer pushes out a partly filled receive entry, with its unused upper bits zeroed.

Top module: `word_pack_bridge`

## Requirements
- R1: After reset, tx_word_valid and rx_ent_valid are 0, and tx_ent_ready and rx_word_ready are 1. Until the first start pulse, the block runs unpacked with 32-bit words.
- R2: Packed mode with pack_code 1 splits each send entry into four 8-bit words. Bits 7:0 come out first, then 15:8, 23:16 and 31:24.
- R3: Packed mode with pack_code 2 splits each send entry into two 16-bit words. Bits 15:0 come out first.
- R4: In unpacked mode each send entry gives exactly one word, equal to the entry masked to word_len_m1+1 bits.
- R5: tx_ent_ready stays low while any word of the held entry is still unconsumed. It rises in the cycle after the last word is taken.
- R6: In packed mode, received words are masked to the unit width and placed from bit 0 upward. An entry is emitted once it holds 32 bits of units: four for pack_code 1, two for pack_code 2.
- R7: In unpacked mode every received word becomes one entry, masked to word_len_m1+1 bits, with the upper bits zero.
- R8: A flush pulse while a packed receive entry is partly filled emits that entry with its unused upper units zero. A flush with no partial words emits nothing.
- R9: The mode, pack_code and word_len_m1 inputs take effect only on a start pulse. Changes between start pulses are ignored.
- R10: A start pulse discards the rest of a held send entry and any partly filled receive entry.
- R11: Under back-pressure, tx_word_data and rx_ent_data hold steady until their handshake completes.
- R12: pack_code 0 gives eight 4-bit units per entry, lowest nibble first. pack_code 3 gives one 32-bit unit per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer start; latches configuration and clears partial state |
| packed_mode | input | 1 | 1 = several words per entry |
| pack_code | input | 2 | Unit size: 0=4, 1=8, 2=16, 3=32 bits |
| word_len_m1 | input | 5 | Word length minus one (unpacked mask) |
| tx_ent_valid | input | 1 | Send entry offered by the FIFO |
| tx_ent_data | input | 32 | Send entry |
| tx_ent_ready | output | 1 | Entry accepted (pop) |
| tx_word_valid | output | 1 | Serial word available |
| tx_word_data | output | 32 | Serial word, right-justified |
| tx_word_ready | input | 1 | Shifter takes the word |
| rx_word_valid | input | 1 | Received word offered |
| rx_word_data | input | 32 | Received word, right-justified |
| rx_word_ready | output | 1 | Received word accepted |
| rx_ent_valid | output | 1 | Assembled entry available |
| rx_ent_data | output | 32 | Assembled entry |
| rx_ent_ready | input | 1 | FIFO takes the entry (push) |
| flush | input | 1 | End-of-transfer flush of a partial receive entry |

## Verification
The hardest states to reach are the ones where partial state meets a control event. Examples are a held send entry with words still pending when a start pulse arrives, or a receive accumulator with one word in it when the transfer is restarted. The stimulus gets there by holding tx_word_ready low and releasing it one cycle at a time, so it stops partway through an entry before pulsing start or flush. A back-pressured receive entry and configuration inputs changed without a start pulse are also covered.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
  localparam int ENTRY_W     = 32;
  localparam int CODE_W      = 2;
  localparam int LEN_W       = 5;
  localparam int UNIT_LG_MIN = 2;
  localparam int LG_W        = 3;
  localparam int SLOT_W      = $clog2(ENTRY_W >> UNIT_LG_MIN);
  localparam int SHAMT_W     = 8;

  typedef struct packed {
    logic              packed_mode;
    logic [CODE_W-1:0] code;
    logic [LEN_W-1:0]  len_m1;
  } cfg_t;

  function automatic logic [ENTRY_W-1:0] low_ones(input int unsigned n);
    logic [ENTRY_W:0] t;
    t = ((ENTRY_W+1)'(1) << n) - (ENTRY_W+1)'(1);
    return t[ENTRY_W-1:0];
  endfunction
endpackage

// File: rtl/wpk_cfg.sv
module wpk_cfg
  import wpk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               packed_mode_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [LEN_W-1:0]   len_m1_i,
  output logic [SLOT_W-1:0]  last_o,
  output logic [LG_W-1:0]    unit_lg_o,
  output logic [ENTRY_W-1:0] mask_o
);
  cfg_t cfg_q, cfg_d;
  logic [LG_W-1:0] lg;

  always_comb begin
    cfg_d = cfg_q;
    if (start) begin
      cfg_d.packed_mode = packed_mode_i;
      cfg_d.code        = code_i;
      cfg_d.len_m1      = len_m1_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.packed_mode <= 1'b0;
      cfg_q.code        <= '0;
      cfg_q.len_m1      <= '1;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    lg = LG_W'(cfg_q.code) + LG_W'(UNIT_LG_MIN);
    if (cfg_q.packed_mode) begin
      unit_lg_o = lg;
      last_o    = SLOT_W'((ENTRY_W >> lg) - 1);
      mask_o    = low_ones(int'(unsigned'(32'd1) << lg));
    end else begin
      unit_lg_o = '0;
      last_o    = '0;
      mask_o    = low_ones(int'(cfg_q.len_m1) + 1);
    end
  end

  // R9: configuration only moves on a start pulse
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(cfg_q));
endmodule

// File: rtl/wpk_tx_unpack.sv
module wpk_tx_unpack
  import wpk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [SLOT_W-1:0]  last,
  input  logic [LG_W-1:0]    unit_lg,
  input  logic [ENTRY_W-1:0] mask,
  input  logic               ent_valid,
  input  logic [ENTRY_W-1:0] ent_data,
  output logic               ent_ready,
  output logic               word_valid,
  output logic [ENTRY_W-1:0] word_data,
  input  logic               word_ready
);
  logic               have_q, have_d;
  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic [ENTRY_W-1:0] hold_q;
  logic               load, take;
  logic [SHAMT_W-1:0] shamt;

  assign ent_ready  = !have_q;
  assign word_valid = have_q;
  assign load       = ent_valid && !have_q;
  assign take       = have_q && word_ready;

  always_comb begin
    have_d = have_q;
    slot_d = slot_q;
    if (take) begin
      if (slot_q == last) have_d = 1'b0;
      else                slot_d = slot_q + 1'b1;
    end
    if (clear) begin
      have_d = 1'b0;
      slot_d = '0;
    end
    if (load) begin
      have_d = 1'b1;
      slot_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      slot_q <= '0;
    end else begin
      have_q <= have_d;
      slot_q <= slot_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) hold_q <= ent_data;
  end

  always_comb begin
    shamt     = SHAMT_W'(slot_q) << unit_lg;
    word_data = (hold_q >> shamt) & mask;
  end

  // R11: an offered word stays put under back-pressure
  p_hold_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready && !clear |=> word_valid && $stable(word_data));
  // R5: a loaded entry offers a word on the next cycle
  p_load_offers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && ent_ready |=> word_valid);
  // R5: no pop while the current entry is stalled
  p_no_pop_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready && !clear |=> !ent_ready);
endmodule

// File: rtl/wpk_rx_pack.sv
module wpk_rx_pack
  import wpk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               flush,
  input  logic [SLOT_W-1:0]  last,
  input  logic [LG_W-1:0]    unit_lg,
  input  logic [ENTRY_W-1:0] mask,
  input  logic               word_valid,
  input  logic [ENTRY_W-1:0] word_data,
  output logic               word_ready,
  output logic               ent_valid,
  output logic [ENTRY_W-1:0] ent_data,
  input  logic               ent_ready
);
  logic [ENTRY_W-1:0] acc_q, acc_d, od_q, od_d, placed, merged;
  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic               pend_q, pend_d, ov_q, ov_d;
  logic               accept, freq;
  logic [SHAMT_W-1:0] shamt;

  assign word_ready = !ov_q;
  assign ent_valid  = ov_q;
  assign ent_data   = od_q;
  assign accept     = word_valid && !ov_q;
  assign freq       = flush || pend_q;

  always_comb begin
    shamt  = SHAMT_W'(slot_q) << unit_lg;
    placed = (word_data & mask) << shamt;
    merged = acc_q | placed;
  end

  always_comb begin
    acc_d  = acc_q;
    slot_d = slot_q;
    pend_d = pend_q;
    ov_d   = ov_q;
    od_d   = od_q;
    if (ov_q) begin
      if (ent_ready) ov_d = 1'b0;
      if (flush)     pend_d = 1'b1;
    end else if (accept) begin
      if (slot_q == last || freq) begin
        ov_d   = 1'b1;
        od_d   = merged;
        acc_d  = '0;
        slot_d = '0;
        pend_d = 1'b0;
      end else begin
        acc_d  = merged;
        slot_d = slot_q + 1'b1;
      end
    end else if (freq) begin
      pend_d = 1'b0;
      if (slot_q != '0) begin
        ov_d   = 1'b1;
        od_d   = acc_q;
        acc_d  = '0;
        slot_d = '0;
      end
    end
    if (clear) begin
      acc_d  = '0;
      slot_d = '0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      slot_q <= '0;
      pend_q <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      slot_q <= slot_d;
      pend_q <= pend_d;
      ov_q   <= ov_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!ov_q) od_q <= od_d;
  end

  // R11: a pending entry holds until taken
  p_hold_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid && !ent_ready |=> ent_valid && $stable(ent_data));
  // R7: a single-unit entry is emitted right after each accepted word
  p_single_emit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (last == '0) |=> ent_valid);
  // R8: flushing an empty accumulator emits nothing
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ov_q && !word_valid && flush && !pend_q && (slot_q == '0) |=> !ent_valid);
endmodule

// File: rtl/word_pack_bridge.sv
module word_pack_bridge
  import wpk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               packed_mode,
  input  logic [CODE_W-1:0]  pack_code,
  input  logic [LEN_W-1:0]   word_len_m1,
  input  logic               tx_ent_valid,
  input  logic [ENTRY_W-1:0] tx_ent_data,
  output logic               tx_ent_ready,
  output logic               tx_word_valid,
  output logic [ENTRY_W-1:0] tx_word_data,
  input  logic               tx_word_ready,
  input  logic               rx_word_valid,
  input  logic [ENTRY_W-1:0] rx_word_data,
  output logic               rx_word_ready,
  output logic               rx_ent_valid,
  output logic [ENTRY_W-1:0] rx_ent_data,
  input  logic               rx_ent_ready,
  input  logic               flush
);
  logic [1:0]         rst_q;
  logic               rst_int_n;
  logic [SLOT_W-1:0]  last;
  logic [LG_W-1:0]    unit_lg;
  logic [ENTRY_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  wpk_cfg u_cfg (
    .clk(clk), .rst_n(rst_int_n), .start(start),
    .packed_mode_i(packed_mode), .code_i(pack_code), .len_m1_i(word_len_m1),
    .last_o(last), .unit_lg_o(unit_lg), .mask_o(mask)
  );

  wpk_tx_unpack u_tx (
    .clk(clk), .rst_n(rst_int_n), .clear(start),
    .last(last), .unit_lg(unit_lg), .mask(mask),
    .ent_valid(tx_ent_valid), .ent_data(tx_ent_data), .ent_ready(tx_ent_ready),
    .word_valid(tx_word_valid), .word_data(tx_word_data), .word_ready(tx_word_ready)
  );

  wpk_rx_pack u_rx (
    .clk(clk), .rst_n(rst_int_n), .clear(start), .flush(flush),
    .last(last), .unit_lg(unit_lg), .mask(mask),
    .word_valid(rx_word_valid), .word_data(rx_word_data), .word_ready(rx_word_ready),
    .ent_valid(rx_ent_valid), .ent_data(rx_ent_data), .ent_ready(rx_ent_ready)
  );
endmodule

// File: tb/word_pack_bridge_test.sv
module word_pack_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, packed_mode = 1'b0, flush = 1'b0;
  logic [1:0]  pack_code = 2'd0;
  logic [4:0]  word_len_m1 = 5'd31;
  logic        tx_ent_valid = 1'b0, tx_word_ready = 1'b1;
  logic [31:0] tx_ent_data = '0, rx_word_data = '0;
  logic        rx_word_valid = 1'b0, rx_ent_ready = 1'b1;
  logic        tx_ent_ready, tx_word_valid, rx_word_ready, rx_ent_valid;
  logic [31:0] tx_word_data, rx_ent_data;

  int errors = 0, checks = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [31:0] tx_exp[$];
  logic [31:0] rx_exp[$];

  bit          m_packed = 0;
  logic [1:0]  m_code = 0;
  logic [4:0]  m_len = 31;
  logic [31:0] racc = 0;
  int          rslot = 0;

  always #10 clk = ~clk;

  word_pack_bridge uut (
    .clk(clk), .rst_n(rst_n), .start(start), .packed_mode(packed_mode),
    .pack_code(pack_code), .word_len_m1(word_len_m1),
    .tx_ent_valid(tx_ent_valid), .tx_ent_data(tx_ent_data), .tx_ent_ready(tx_ent_ready),
    .tx_word_valid(tx_word_valid), .tx_word_data(tx_word_data), .tx_word_ready(tx_word_ready),
    .rx_word_valid(rx_word_valid), .rx_word_data(rx_word_data), .rx_word_ready(rx_word_ready),
    .rx_ent_valid(rx_ent_valid), .rx_ent_data(rx_ent_data), .rx_ent_ready(rx_ent_ready),
    .flush(flush)
  );

  function automatic logic [31:0] ones(input int n);
    logic [32:0] t;
    t = (33'd1 << n) - 33'd1;
    return t[31:0];
  endfunction

  function automatic int unit_w();
    return m_packed ? (4 << m_code) : 32;
  endfunction

  function automatic logic [31:0] m_mask();
    return m_packed ? ones(4 << m_code) : ones(int'(m_len) + 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitors
  always @(negedge clk) begin
    if (rst_n && tx_word_valid && tx_word_ready) begin
      checks++;
      if (tx_exp.size() == 0) begin
        errors++;
        $display("FAIL %s actual=%h expected=none (unexpected send word)", cur_req, tx_word_data);
      end else begin
        logic [31:0] e;
        e = tx_exp.pop_front();
        if (tx_word_data !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h (send word)", cur_req, tx_word_data, e);
        end
      end
    end
    if (rst_n && rx_ent_valid && rx_ent_ready) begin
      checks++;
      if (rx_exp.size() == 0) begin
        errors++;
        $display("FAIL %s actual=%h expected=none (unexpected entry)", cur_req, rx_ent_data);
      end else begin
        logic [31:0] e;
        e = rx_exp.pop_front();
        if (rx_ent_data !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h (entry)", cur_req, rx_ent_data, e);
        end
      end
    end
  end

  task automatic do_start(input bit pk, input logic [1:0] cd, input logic [4:0] ln);
    @(posedge clk); #1;
    packed_mode = pk; pack_code = cd; word_len_m1 = ln; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    m_packed = pk; m_code = cd; m_len = ln;
    tx_exp.delete();
    racc = 0; rslot = 0;
  endtask

  task automatic tx_push(input logic [31:0] e);
    if (m_packed) begin
      for (int i = 0; i < (32 / unit_w()); i++)
        tx_exp.push_back((e >> (i * unit_w())) & m_mask());
    end else begin
      tx_exp.push_back(e & m_mask());
    end
    @(posedge clk); #1;
    tx_ent_valid = 1'b1; tx_ent_data = e;
    do @(negedge clk); while (!tx_ent_ready);
    @(posedge clk); #1;
    tx_ent_valid = 1'b0;
  endtask

  task automatic rx_push(input logic [31:0] w);
    if (m_packed) begin
      racc = racc | ((w & m_mask()) << (rslot * unit_w()));
      rslot++;
      if (rslot == 32 / unit_w()) begin
        rx_exp.push_back(racc); racc = 0; rslot = 0;
      end
    end else begin
      rx_exp.push_back(w & m_mask());
    end
    @(posedge clk); #1;
    rx_word_valid = 1'b1; rx_word_data = w;
    do @(negedge clk); while (!rx_word_ready);
    @(posedge clk); #1;
    rx_word_valid = 1'b0;
  endtask

  task automatic do_flush();
    if (rslot != 0) begin
      rx_exp.push_back(racc); racc = 0; rslot = 0;
    end
    @(posedge clk); #1; flush = 1'b1;
    @(posedge clk); #1; flush = 1'b0;
  endtask

  task automatic take_one();
    @(posedge clk); #1; tx_word_ready = 1'b1;
    @(posedge clk); #1; tx_word_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    @(negedge clk);
    // R1 reset state
    chk("R1", 32'(tx_word_valid), 0);
    chk("R1", 32'(rx_ent_valid), 0);
    chk("R1", 32'(tx_ent_ready), 1);
    chk("R1", 32'(rx_word_ready), 1);
    // R1 default configuration: unpacked 32-bit
    tx_push(32'h1234_5678);
    rx_push(32'hDEAD_BEEF);
    idle(6);

    // R2 send 8-bit packing
    cur_req = "R2";
    do_start(1, 2'd1, 5'd7);
    tx_push(32'hA1B2_C3D4);
    tx_push(32'h0102_0304);
    idle(8);

    // R6 receive 8-bit packing, masking to unit
    cur_req = "R6";
    rx_push(32'h11); rx_push(32'h22); rx_push(32'h33); rx_push(32'h144);
    idle(4);

    // R3 16-bit packing both ways
    cur_req = "R3";
    do_start(1, 2'd2, 5'd15);
    tx_push(32'hCAFE_BEEF);
    rx_push(32'h1234); rx_push(32'hF_5678);
    idle(6);

    // R12 nibble units and full-width unit
    cur_req = "R12";
    do_start(1, 2'd0, 5'd3);
    tx_push(32'h8765_4321);
    idle(10);
    do_start(1, 2'd3, 5'd31);
    tx_push(32'hF00D_F00D);
    rx_push(32'h0BAD_CAFE);
    idle(6);

    // R4 / R7 unpacked with 12-bit words
    cur_req = "R4";
    do_start(0, 2'd1, 5'd11);
    tx_push(32'hFFFF_F5A5);
    tx_push(32'h0000_0FFF);
    idle(4);
    cur_req = "R7";
    rx_push(32'hABCD_E123);
    rx_push(32'h0000_1800);
    idle(4);

    // R8 flush of partial entries
    cur_req = "R8";
    do_start(1, 2'd1, 5'd7);
    rx_push(32'hAA); rx_push(32'hBB);
    do_flush();
    idle(3);
    do_flush();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8", 32'(rx_ent_valid), 0);
    end
    do_start(1, 2'd2, 5'd15);
    rx_push(32'h7777);
    do_flush();
    idle(4);

    // R5 pop only after all words consumed
    cur_req = "R5";
    do_start(1, 2'd1, 5'd7);
    tx_word_ready = 1'b0;
    tx_push(32'h4433_2211);
    @(negedge clk);
    chk("R5", 32'(tx_ent_ready), 0);
    chk("R5", 32'(tx_word_valid), 1);
    take_one(); take_one(); take_one();
    @(negedge clk);
    chk("R5", 32'(tx_ent_ready), 0);
    take_one();
    @(negedge clk);
    chk("R5", 32'(tx_ent_ready), 1);

    // R11 stability under back-pressure
    cur_req = "R11";
    tx_push(32'h0D0C_0B0A);
    idle(2);
    @(negedge clk);
    chk("R11", tx_word_data, 32'h0A);
    idle(1);
    @(negedge clk);
    chk("R11", tx_word_data, 32'h0A);
    tx_word_ready = 1'b1;
    idle(6);
    rx_ent_ready = 1'b0;
    rx_push(32'h01); rx_push(32'h02); rx_push(32'h03); rx_push(32'h04);
    idle(3);
    @(negedge clk);
    chk("R11", 32'(rx_ent_valid), 1);
    chk("R11", rx_ent_data, 32'h0403_0201);
    @(posedge clk); #1 rx_ent_ready = 1'b1;
    idle(3);

    // R9 configuration inputs ignored without start
    cur_req = "R9";
    packed_mode = 1'b0; pack_code = 2'd2; word_len_m1 = 5'd3;
    tx_push(32'h5566_7788);
    rx_push(32'hE1); rx_push(32'hE2); rx_push(32'hE3); rx_push(32'hE4);
    idle(8);

    // R10 start discards partial state on both sides
    cur_req = "R10";
    tx_word_ready = 1'b0;
    tx_push(32'h0F0E_0D0C);
    take_one();
    rx_push(32'h99);
    do_start(1, 2'd1, 5'd7);
    @(negedge clk);
    chk("R10", 32'(tx_word_valid), 0);
    chk("R10", 32'(tx_ent_ready), 1);
    tx_word_ready = 1'b1;
    rx_push(32'h01); rx_push(32'h02); rx_push(32'h03); rx_push(32'h04);
    idle(6);

    cur_req = "R2";
    chk("R2", 32'(tx_exp.size()), 0);
    chk("R6", 32'(rx_exp.size()), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule